// File: doc/BRIEF.md
# Flyby DRAM-to-I/O Transfer Sequencer

This block times a single flyby DMA move in which a word is read out of DRAM and written straight into an external I/O device in the same bus cycle, with no internal staging. It drives the multiplexed DRAM address, the row and column strobes, the write enable, the read strobe toward the memory and the write strobe toward the I/O device. Each strobe edge is placed by summing several programmable wait counts, and the external wait input can stretch the cycle.

The sequencer runs on `clk`, which is a tick at twice the bus clock rate. One bus clock is two ticks, so half-clock offsets are exact. Even tick counts from the start of the cycle are rising bus edges and odd counts are falling bus edges. A one-tick `start` in the idle state captures both addresses and all wait fields. The block then plays the cycle and any trailing idle states, and finishes with a one-tick `done`. All strobes are active low. Tick counts below are measured from the tick on which `addrValid` rises, written as tick 0. `w` is the number of accepted wait samples, and `rp`, `rh`, `da`, `sf` and `idl` are the values of `rpWait`, `rhWait`, `daWait`, `srcWait` and `idleStates` captured at start.

Top module: `flyby_seq`

## Requirements
- R1: While reset is asserted and after it is released, the outputs are `rasN`, `casN`, `oeN`, `iowrN` and `weN` all high, `addrValid` low and `done` low, until a start is accepted.
- R2: `start` is accepted only when the block is idle. The addresses and wait fields are captured at acceptance. A `start` pulse or field change during a cycle does not restart the cycle, does not alter its timing and does not change the address driven.
- R3: `addrValid` stays high for exactly 6 + 2(rp + rh + da + sf + w) ticks.
- R4: The row address is driven from tick 0. `rasN` and `iowrN` both fall at tick 1 + 2rp.
- R5: `dramAddr` switches to the column address at tick 2 + 2rp + 2rh, and `casN` falls one tick later.
- R6: `casN` stays low for 2 + 2(da + sf + w) ticks. `rasN` rises one tick after `casN` rises, on the same tick that `addrValid` falls.
- R7: `oeN` is low exactly while `casN` is low. With sf = 0, `iowrN` rises on the same tick as `oeN`. With sf = 1, `iowrN` rises two ticks (one bus clock) earlier.
- R8: `waitReq` is sampled only on falling-edge ticks, only while `casN` is low and `iowrN` is still low. Each sample found high adds two ticks to the CAS-low span, the IOWR-low span and the whole cycle.
- R9: `weN` stays high for the whole transfer, because the DRAM is only read.
- R10: `done` is high for exactly one tick, 2·idl ticks after `addrValid` falls. All strobes are inactive while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer tick, twice the bus clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one transfer (taken only when idle) |
| rowAddr | input | AW | DRAM row address |
| colAddr | input | AW | DRAM column address |
| waitReq | input | 1 | External wait, active high |
| rpWait | input | WW | Extra RAS precharge clocks |
| rhWait | input | WW | Extra row hold clocks |
| daWait | input | WW | Extra data access clocks |
| srcWait | input | 1 | Flyby source-side wait (0 or 1 clock) |
| idleStates | input | IW | Idle clocks appended after the cycle |
| dramAddr | output | AW | Multiplexed row/column address |
| addrValid | output | 1 | Address bus carries a valid address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | DRAM write enable, active low |
| oeN | output | 1 | DRAM read strobe, active low |
| iowrN | output | 1 | I/O write strobe, active low |
| done | output | 1 | One-tick transfer completion pulse |

## Verification
The hardest case to reach from the ports is an exact count of wait stalls. A wait only counts when `waitReq` is high on a falling-edge tick while the column strobe and the I/O write are both low. When the access wait is zero, there is just one such tick before the strobes would release. When the source wait is set, the last falling edge before CAS rises no longer counts, because IOWR has already gone high. The bench counts ticks from the rise of `addrValid` and computes the tick at which CAS falls. It then holds `waitReq` high over a window of 2w−1 ticks starting on that tick, so exactly w sample points see it. The vectors include a zero access wait and a source wait of one, so both edges of the sampling window are exercised.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROWH,
    ST_CASD,
    ST_ACC,
    ST_TAIL,
    ST_GAP,
    ST_DONE
  } seqState_t;

  // Strobe levels from control to datapath, all active high here.
  typedef struct packed {
    logic load;    // capture addresses this tick
    logic addrOn;  // address bus valid
    logic selCol;  // drive column instead of row
    logic ras;
    logic cas;
    logic oe;
    logic iowr;
    logic done;
  } strobes_t;

endpackage

// File: rtl/flyby_ctrl.sv
module flyby_ctrl
  import flyby_pkg::*;
#(
  parameter int WW = 2,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          waitReq,
  input  logic [WW-1:0] rpWait,
  input  logic [WW-1:0] rhWait,
  input  logic [WW-1:0] daWait,
  input  logic          srcWait,
  input  logic [IW-1:0] idleStates,
  output strobes_t      strb
);

  localparam int MW = (WW > IW) ? WW : IW;
  localparam int CW = MW + 3;

  seqState_t     state;
  logic [CW-1:0] cnt;
  logic [WW-1:0] rhQ, daQ;
  logic          sfQ;
  logic [IW-1:0] idQ;

  logic [CW-1:0] accLoad;
  logic [CW-1:0] srcSpan;
  logic          stallNow;
  logic          cntZero;

  assign srcSpan  = CW'(sfQ) << 1;
  assign accLoad  = (CW'(daQ) << 1) + srcSpan + CW'(1);
  assign cntZero  = (cnt == '0);
  // falling-edge ticks have odd count; sampling stops once IOWR has risen
  assign stallNow = (state == ST_ACC) && cnt[0] && (cnt >= srcSpan + CW'(1)) && waitReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      rhQ   <= '0;
      daQ   <= '0;
      sfQ   <= 1'b0;
      idQ   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_PRE;
            cnt   <= CW'(rpWait) << 1;
            rhQ   <= rhWait;
            daQ   <= daWait;
            sfQ   <= srcWait;
            idQ   <= idleStates;
          end
        end
        ST_PRE: begin
          if (cntZero) begin
            state <= ST_ROWH;
            cnt   <= CW'(rhQ) << 1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_ROWH: begin
          if (cntZero) begin
            state <= ST_CASD;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_CASD: begin
          state <= ST_ACC;
          cnt   <= accLoad;
        end
        ST_ACC: begin
          if (stallNow) begin
            cnt <= cnt + CW'(1);
          end else if (cntZero) begin
            state <= ST_TAIL;
            cnt   <= '0;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_TAIL: begin
          if (idQ == '0) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            state <= ST_GAP;
            cnt   <= (CW'(idQ) << 1) - CW'(1);
          end
        end
        ST_GAP: begin
          if (cntZero) begin
            state <= ST_DONE;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && start;
    strb.addrOn = (state == ST_PRE) || (state == ST_ROWH) || (state == ST_CASD) ||
                  (state == ST_ACC) || (state == ST_TAIL);
    strb.selCol = (state == ST_CASD) || (state == ST_ACC) || (state == ST_TAIL);
    strb.ras    = (state == ST_ROWH) || (state == ST_CASD) || (state == ST_ACC) ||
                  (state == ST_TAIL);
    strb.cas    = (state == ST_ACC);
    strb.oe     = (state == ST_ACC);
    strb.iowr   = (state == ST_ROWH) || (state == ST_CASD) ||
                  ((state == ST_ACC) && !(sfQ && (cnt < CW'(2))));
    strb.done   = (state == ST_DONE);
  end

endmodule

// File: rtl/flyby_dpath.sv
module flyby_dpath
  import flyby_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic [AW-1:0] rowAddr,
  input  logic [AW-1:0] colAddr,
  output logic [AW-1:0] dramAddr,
  output logic          addrValid,
  output logic          rasN,
  output logic          casN,
  output logic          oeN,
  output logic          iowrN,
  output logic          done
);

  logic [AW-1:0] rowQ, colQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ <= '0;
      colQ <= '0;
    end else if (strb.load) begin
      rowQ <= rowAddr;
      colQ <= colAddr;
    end
  end

  // every pin leaves a flop so all edges share one tick of latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramAddr  <= '0;
      addrValid <= 1'b0;
      rasN      <= 1'b1;
      casN      <= 1'b1;
      oeN       <= 1'b1;
      iowrN     <= 1'b1;
      done      <= 1'b0;
    end else begin
      dramAddr  <= strb.selCol ? colQ : rowQ;
      addrValid <= strb.addrOn;
      rasN      <= !strb.ras;
      casN      <= !strb.cas;
      oeN       <= !strb.oe;
      iowrN     <= !strb.iowr;
      done      <= strb.done;
    end
  end

endmodule

// File: rtl/flyby_seq.sv
module flyby_seq
  import flyby_pkg::*;
#(
  parameter int AW = 12,
  parameter int WW = 2,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] rowAddr,
  input  logic [AW-1:0] colAddr,
  input  logic          waitReq,
  input  logic [WW-1:0] rpWait,
  input  logic [WW-1:0] rhWait,
  input  logic [WW-1:0] daWait,
  input  logic          srcWait,
  input  logic [IW-1:0] idleStates,
  output logic [AW-1:0] dramAddr,
  output logic          addrValid,
  output logic          rasN,
  output logic          casN,
  output logic          weN,
  output logic          oeN,
  output logic          iowrN,
  output logic          done
);

  strobes_t strb;

  flyby_ctrl #(.WW(WW), .IW(IW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .waitReq    (waitReq),
    .rpWait     (rpWait),
    .rhWait     (rhWait),
    .daWait     (daWait),
    .srcWait    (srcWait),
    .idleStates (idleStates),
    .strb       (strb)
  );

  flyby_dpath #(.AW(AW)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rowAddr   (rowAddr),
    .colAddr   (colAddr),
    .dramAddr  (dramAddr),
    .addrValid (addrValid),
    .rasN      (rasN),
    .casN      (casN),
    .oeN       (oeN),
    .iowrN     (iowrN),
    .done      (done)
  );

  // flyby source side is read-only: DRAM write enable never asserts (R9)
  assign weN = 1'b1;

endmodule

// File: rtl/flyby_seq_chk.sv
module flyby_seq_chk (
  input logic clk,
  input logic rstN,
  input logic addrValid,
  input logic rasN,
  input logic casN,
  input logic oeN,
  input logic iowrN,
  input logic done
);

  // R4: I/O write only while the address is valid
  a_r4_iowr_in_addr: assert property (@(posedge clk) disable iff (!rstN)
    !iowrN |-> addrValid);

  // R5: column strobe falls only after the row strobe is already low
  a_r5_cas_after_ras: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> !$past(rasN));

  // R6: CAS low lies inside RAS low
  a_r6_cas_in_ras: assert property (@(posedge clk) disable iff (!rstN)
    !casN |-> !rasN);

  // R6: RAS release ends the address window
  a_r6_ras_ends_addr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> !addrValid);

  // R7: read strobe never ends before the I/O write
  a_r7_iowr_before_oe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeN) |-> iowrN);

  // R10: done only with the bus quiet
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rasN && casN && oeN && iowrN && !addrValid));

  // R10: done lasts one tick
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind flyby_seq flyby_seq_chk u_flyby_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrValid (addrValid),
  .rasN      (rasN),
  .casN      (casN),
  .oeN       (oeN),
  .iowrN     (iowrN),
  .done      (done)
);

// File: tb/tb_flyby_seq.sv
`timescale 1ns/1ps
module tb_flyby_seq;
  localparam int AW = 12;
  localparam int WW = 2;
  localparam int IW = 2;
  localparam int NV = 6;
  // fields: rp[10:9] rh[8:7] da[6:5] sf[4] idl[3:2] w[1:0]
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 2'd0},
    {2'd1, 2'd0, 2'd0, 1'b0, 2'd1, 2'd0},
    {2'd0, 2'd2, 2'd1, 1'b1, 2'd0, 2'd0},
    {2'd3, 2'd3, 2'd3, 1'b1, 2'd3, 2'd2},
    {2'd1, 2'd1, 2'd0, 1'b0, 2'd0, 2'd3},
    {2'd2, 2'd0, 2'd2, 1'b1, 2'd2, 2'd1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN, start, waitReq, srcWait;
  logic [AW-1:0] rowAddr, colAddr;
  logic [WW-1:0] rpWait, rhWait, daWait;
  logic [IW-1:0] idleStates;
  logic [AW-1:0] dramAddr;
  logic          addrValid, rasN, casN, weN, oeN, iowrN, done;

  int errors = 0;
  int checks = 0;

  flyby_seq #(.AW(AW), .WW(WW), .IW(IW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .rowAddr(rowAddr), .colAddr(colAddr),
    .waitReq(waitReq), .rpWait(rpWait), .rhWait(rhWait), .daWait(daWait),
    .srcWait(srcWait), .idleStates(idleStates), .dramAddr(dramAddr),
    .addrValid(addrValid), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .iowrN(iowrN), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runVec(input int rp, input int rh, input int da, input int sf,
                        input int idl, input int w, input logic [AW-1:0] row,
                        input logic [AW-1:0] col, input bit poke);
    int h, rasF, rasR, iowrF, iowrR, colT, casF, casR, oeF, oeR, endT, doneT;
    int doneN, weSeen, reAddr, rowOk, cf, cr, expEnd, expDone;
    h = -1; rasF = -1; rasR = -1; iowrF = -1; iowrR = -1; colT = -1;
    casF = -1; casR = -1; oeF = -1; oeR = -1; endT = -1; doneT = -1;
    doneN = 0; weSeen = 0; reAddr = 0; rowOk = 0;
    cf      = 3 + 2*rp + 2*rh;
    cr      = 5 + 2*(rp + rh + da + sf + w);
    expEnd  = cr + 1;
    expDone = expEnd + 2*idl;
    @(negedge clk);
    rpWait = WW'(rp); rhWait = WW'(rh); daWait = WW'(da);
    srcWait = sf[0]; idleStates = IW'(idl);
    rowAddr = row; colAddr = col; waitReq = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 600 && h < expDone + 6; k++) begin
      @(negedge clk);
      if (h < 0) begin
        if (addrValid) h = 0;
      end else begin
        h++;
      end
      if (h >= 0) begin
        if (h == 0 && dramAddr == row) rowOk = 1;
        if (!rasN && rasF < 0) rasF = h;
        if (rasF >= 0 && rasN && rasR < 0) rasR = h;
        if (!iowrN && iowrF < 0) iowrF = h;
        if (iowrF >= 0 && iowrN && iowrR < 0) iowrR = h;
        if (addrValid && dramAddr == col && colT < 0) colT = h;
        if (!casN && casF < 0) casF = h;
        if (casF >= 0 && casN && casR < 0) casR = h;
        if (!oeN && oeF < 0) oeF = h;
        if (oeF >= 0 && oeN && oeR < 0) oeR = h;
        if (!addrValid && endT < 0) endT = h;
        if (endT >= 0 && addrValid) reAddr = 1;
        if (done) begin
          doneN++;
          if (doneT < 0) doneT = h;
        end
        if (!weN) weSeen = 1;
      end
      // WAIT high over 2w-1 ticks from the CAS-fall tick hits w sample points
      waitReq = (h >= 0) && (w > 0) && (h + 1 >= cf) && (h + 1 <= cf + 2*w - 2);
      if (poke && h == 2) begin
        start = 1'b1; rowAddr = ~row; colAddr = ~col;
        rpWait = ~WW'(rp); srcWait = ~sf[0]; idleStates = ~IW'(idl);
      end else begin
        start = 1'b0;
      end
    end
    waitReq = 1'b0;
    chk("R4 row address at tick 0", rowOk, 1);
    chk("R4 rasN fall tick", rasF, 1 + 2*rp);
    chk("R4 iowrN fall tick", iowrF, 1 + 2*rp);
    chk("R5 column address tick", colT, 2 + 2*rp + 2*rh);
    chk("R5 casN fall tick", casF, cf);
    chk((w > 0) ? "R8 casN low span with waits" : "R6 casN low span", casR - casF, 2 + 2*(da + sf + w));
    chk("R6 rasN rise tick", rasR, expEnd);
    chk((w > 0) ? "R8 cycle length with waits" : "R3 cycle length", endT, expEnd);
    chk("R7 oeN fall tick", oeF, cf);
    chk("R7 oeN rise tick", oeR, cr);
    chk((w > 0) ? "R8 iowrN rise tick" : "R7 iowrN rise tick", iowrR, cr - 2*sf);
    chk("R10 done tick", doneT, expDone);
    chk("R10 done width", doneN, 1);
    chk("R9 weN stayed high", weSeen, 0);
    if (poke) chk("R2 no restart while busy", reAddr, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; waitReq = 1'b0; srcWait = 1'b0;
    rowAddr = '0; colAddr = '0; rpWait = '0; rhWait = '0; daWait = '0; idleStates = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, also with start held during reset
    start = 1'b1;
    @(negedge clk);
    chk("R1 strobes inactive in reset", {rasN, casN, oeN, iowrN, weN}, 5'b11111);
    chk("R1 addrValid low in reset", addrValid, 0);
    start = 1'b0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 strobes inactive after reset", {rasN, casN, oeN, iowrN, weN}, 5'b11111);
    chk("R1 idle without start", {addrValid, done}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      runVec(int'(VEC[v][10:9]), int'(VEC[v][8:7]), int'(VEC[v][6:5]),
             int'(VEC[v][4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]),
             AW'(12'h0A5 + v), AW'(12'h35C ^ v), 1'b0);
    end

    // R2: start and field changes mid-cycle are ignored
    runVec(1, 2, 1, 0, 1, 0, AW'(12'h123), AW'(12'h456), 1'b1);
    // R2: back-to-back acceptance after the ignored request
    runVec(0, 1, 0, 1, 0, 1, AW'(12'h7E1), AW'(12'h18E), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule